// File: doc/BRIEF.md
# Pipelined Segmented Phase Accumulator

This block is the phase register of a direct digital frequency synthesizer. On every enabled clock it adds a 24-bit frequency tuning word to a running phase. The phase wraps naturally modulo 2^24, so the rate at which it cycles sets the synthesized frequency. The phase-to-amplitude lookup and the converter that follow it are outside this block.

To keep the critical path short, the 24-bit sum is cut into three 8-bit slices, one per pipeline stage. Inside each slice the sum and carry are formed with generate/propagate carry-lookahead logic. The carry leaving a slice is registered and enters the next-higher slice one clock later. Skew registers delay the upper tuning-word bytes to match that timing. Deskew registers on the lower phase bytes put the three bytes back together into one coherent word. A tuning word sampled on an enabled edge is therefore included in the phase presented after the second enabled edge that follows it.

Top module: `phase_acc_pipe`

## Requirements
- R1: The phase is 24 bits wide. Sums that pass 2^24 wrap modulo 2^24 and never saturate.
- R2: After reset, the value of `phase_o` after the n-th enabled rising edge equals the modulo-2^24 sum of the `ftw_i` values sampled on enabled edges 1 to n-2. The latency is three edges, counting the edge that samples the word.
- R3: The slices cover bits 7:0, 15:8 and 23:16. A carry out of a lower byte reaches the next byte in the same presented phase word, for example 0x0000FF + 0x000001 = 0x000100.
- R4: A carry entering a slice in which every bit propagates crosses the whole slice, so that 0xFFFFFF added to a nonzero phase decrements it by one.
- R5: While the asynchronous active-low reset `rst_ni` is low, every slice, carry and skew register is cleared, and `phase_o` reads 0 at once, without waiting for a clock edge.
- R6: While `en_i` is low, `phase_o` and all internal pipeline state hold, whatever value `ftw_i` has. On resume the sequence continues as if the idle cycles had not occurred, with no carry lost or added.
- R7: After a change of tuning word, the increment of `phase_o` switches from the old word to the new word in exactly one edge, after the fixed latency. No presented word mixes bytes from both tuning words.
- R8: The lowest slice has a carry-in of zero, so a tuning word of 0 leaves the phase constant once the pipeline has drained.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| en_i | input | 1 | Advance enable; when low the whole pipeline holds |
| ftw_i | input | 24 | Frequency tuning word added on each enabled edge |
| phase_o | output | 24 | Aligned phase word |

## Verification
On every cycle the assertions check that an idle cycle freezes the output and that each enabled edge moves the output by exactly the tuning word sampled two enabled edges earlier. They also compare the output against an independent shadow accumulator and confirm that the output is zero during reset. These checks together cover wrap, inter-slice carries and latency in whatever traffic occurs. Only the bench's scenarios can show the specific corner patterns: full propagate chains through all three slices, carries across a byte boundary, the clean step at a tuning-word change, resumption after long stalls with a changing `ftw_i`, and a reset asserted in mid-run that clears the output between clock edges.

// File: rtl/pacc_pkg.sv
package pacc_pkg;
  // Width of one adder slice and number of pipelined slices.
  localparam int PACC_SLICE_W = 8;
  localparam int PACC_SLICES  = 3;
  localparam int PACC_ACC_W   = PACC_SLICE_W * PACC_SLICES;
endpackage

// File: rtl/pacc_cla.sv
// Carry-lookahead adder of W bits. Each carry is formed directly from
// generate/propagate terms rather than by chaining the previous carry.
module pacc_cla #(
  parameter int W = 8,
  parameter bit CARRY_OUT = 1'b1,
  localparam int OUT_W = W + (CARRY_OUT ? 1 : 0)
) (
  input  logic [W-1:0]     a_i,
  input  logic [W-1:0]     b_i,
  input  logic             c_i,
  output logic [OUT_W-1:0] res_o
);

  logic [W-1:0] gen;
  logic [W-1:0] prop;
  logic [W-1:0] cry;
  logic [W-1:0] sum;

  // Carry into bit position idx, expanded as a sum of products.
  function automatic logic carry_into(input logic [W-1:0] g, input logic [W-1:0] p,
                                      input logic cin, input int idx);
    logic acc;
    logic run;
    acc = 1'b0;
    run = 1'b1;
    for (int j = W - 1; j >= 0; j--) begin
      if (j < idx) begin
        acc = acc | (run & g[j]);
        run = run & p[j];
      end
    end
    return acc | (run & cin);
  endfunction

  assign gen  = a_i & b_i;
  assign prop = a_i ^ b_i;

  for (genvar i = 0; i < W; i++) begin : g_cry
    assign cry[i] = carry_into(gen, prop, c_i, i);
  end

  assign sum = prop ^ cry;

  if (CARRY_OUT) begin : g_co
    assign res_o = {carry_into(gen, prop, c_i, W), sum};
  end else begin : g_noco
    assign res_o = sum;
  end

endmodule

// File: rtl/pacc_delay.sv
// Enabled shift line of DEPTH registers (DEPTH >= 1).
module pacc_delay #(
  parameter int W = 8,
  parameter int DEPTH = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [DEPTH-1:0][W-1:0] stg_q;
  logic [DEPTH-1:0][W-1:0] stg_d;

  always_comb begin
    stg_d = stg_q;
    if (en_i) begin
      stg_d[0] = d_i;
      for (int k = 1; k < DEPTH; k++) begin
        stg_d[k] = stg_q[k-1];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= '0;
    end else begin
      stg_q <= stg_d;
    end
  end

  assign q_o = stg_q[DEPTH-1];

endmodule

// File: rtl/pacc_slice.sv
// One accumulator slice: W-bit phase register plus, unless it is the
// top slice, a registered carry presented above the sum bits.
module pacc_slice #(
  parameter int W = 8,
  parameter bit CARRY_OUT = 1'b1,
  localparam int OUT_W = W + (CARRY_OUT ? 1 : 0)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [W-1:0]     addend_i,
  input  logic             carry_i,
  output logic [OUT_W-1:0] state_o
);

  logic [OUT_W-1:0] st_q;
  logic [OUT_W-1:0] st_d;
  logic [OUT_W-1:0] res;

  pacc_cla #(
    .W        (W),
    .CARRY_OUT(CARRY_OUT)
  ) u_cla (
    .a_i  (st_q[W-1:0]),
    .b_i  (addend_i),
    .c_i  (carry_i),
    .res_o(res)
  );

  always_comb begin
    st_d = en_i ? res : st_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= '0;
    end else begin
      st_q <= st_d;
    end
  end

  assign state_o = st_q;

endmodule

// File: rtl/phase_acc_pipe.sv
module phase_acc_pipe #(
  parameter int SLICE_W  = pacc_pkg::PACC_SLICE_W,
  parameter int N_SLICES = pacc_pkg::PACC_SLICES,
  localparam int ACC_W   = SLICE_W * N_SLICES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [ACC_W-1:0] ftw_i,
  output logic [ACC_W-1:0] phase_o
);

  logic [N_SLICES-1:0][SLICE_W-1:0] slc_sum;
  logic [N_SLICES-1:0]              cin;

  // The lowest slice never receives a carry.
  assign cin[0] = 1'b0;

  for (genvar k = 0; k < N_SLICES; k++) begin : g_slc
    logic [SLICE_W-1:0] addend;

    // Input skew: byte k of the tuning word waits k enabled edges.
    if (k == 0) begin : g_noskew
      assign addend = ftw_i[SLICE_W-1:0];
    end else begin : g_skew
      pacc_delay #(
        .W    (SLICE_W),
        .DEPTH(k)
      ) u_skew (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .en_i  (en_i),
        .d_i   (ftw_i[k*SLICE_W +: SLICE_W]),
        .q_o   (addend)
      );
    end

    // Slice with a registered carry to the next one, or the top slice.
    if (k < N_SLICES - 1) begin : g_mid
      logic [SLICE_W:0] word;
      pacc_slice #(
        .W        (SLICE_W),
        .CARRY_OUT(1'b1)
      ) u_slice (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .en_i    (en_i),
        .addend_i(addend),
        .carry_i (cin[k]),
        .state_o (word)
      );
      assign slc_sum[k] = word[SLICE_W-1:0];
      assign cin[k+1]   = word[SLICE_W];
    end else begin : g_top
      logic [SLICE_W-1:0] word;
      pacc_slice #(
        .W        (SLICE_W),
        .CARRY_OUT(1'b0)
      ) u_slice (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .en_i    (en_i),
        .addend_i(addend),
        .carry_i (cin[k]),
        .state_o (word)
      );
      assign slc_sum[k] = word;
    end

    // Output deskew: byte k waits for the slices above it.
    if (k < N_SLICES - 1) begin : g_deskew
      pacc_delay #(
        .W    (SLICE_W),
        .DEPTH(N_SLICES - 1 - k)
      ) u_deskew (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .en_i  (en_i),
        .d_i   (slc_sum[k]),
        .q_o   (phase_o[k*SLICE_W +: SLICE_W])
      );
    end else begin : g_direct
      assign phase_o[k*SLICE_W +: SLICE_W] = slc_sum[k];
    end
  end

endmodule

// File: rtl/pacc_chk.sv
module pacc_chk #(
  parameter int ACC_W = 24
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic [ACC_W-1:0] ftw_i,
  input logic [ACC_W-1:0] phase_o
);

  logic [ACC_W-1:0] fd0;
  logic [ACC_W-1:0] fd1;
  logic [ACC_W-1:0] sh0;
  logic [ACC_W-1:0] sh1;
  logic [ACC_W-1:0] sh2;

  // Shadow of the tuning-word history and of a plain accumulator.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fd0 <= '0;
      fd1 <= '0;
      sh0 <= '0;
      sh1 <= '0;
      sh2 <= '0;
    end else if (en_i) begin
      fd0 <= ftw_i;
      fd1 <= fd0;
      sh0 <= sh0 + ftw_i;
      sh1 <= sh0;
      sh2 <= sh1;
    end
  end

  // R5
  reset_clear_chk: assert property (@(posedge clk_i)
    !rst_ni |-> phase_o == '0);

  // R6
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(phase_o));

  // R7
  step_add_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> phase_o == ACC_W'($past(phase_o) + $past(fd1)));

  // R2
  model_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o == sh2);

endmodule

bind phase_acc_pipe pacc_chk #(
  .ACC_W(SLICE_W * N_SLICES)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .en_i   (en_i),
  .ftw_i  (ftw_i),
  .phase_o(phase_o)
);

// File: tb/sim_phase_acc_pipe.sv
`timescale 1ns/1ps
module sim_phase_acc_pipe;

  logic        clk = 1'b0;
  logic        rst_ni;
  logic        en_i;
  logic [23:0] ftw_i;
  logic [23:0] phase_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // Reference: three-deep history of a plain 24-bit accumulator.
  logic [23:0] r0, r1, r2;

  always #4 clk = ~clk;

  phase_acc_pipe u0 (
    .clk_i  (clk),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .ftw_i  (ftw_i),
    .phase_o(phase_o)
  );

  // {enable, tuning word}
  localparam logic [24:0] VEC [16] = '{
    {1'b1, 24'h000001}, {1'b1, 24'h0000FF}, {1'b1, 24'h00FF01}, {1'b1, 24'h123456},
    {1'b0, 24'hDEAD00}, {1'b1, 24'hFFFFFF}, {1'b1, 24'h800000}, {1'b1, 24'hABCDEF},
    {1'b0, 24'h000000}, {1'b0, 24'h7F7F7F}, {1'b1, 24'h010101}, {1'b1, 24'hFEFEFF},
    {1'b1, 24'h000000}, {1'b1, 24'hC0FFEE}, {1'b1, 24'h00FFFF}, {1'b1, 24'h7FFFFF}
  };

  task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp_v);
    n_chk++;
    if (act !== exp_v) begin
      n_bad++;
      $display("FAIL %s: phase_o=%h expected %h", tag, act, exp_v);
    end
  endtask

  task automatic step(input logic en, input logic [23:0] f, input string tag);
    en_i  = en;
    ftw_i = f;
    @(posedge clk);
    if (en) begin
      r2 = r1;
      r1 = r0;
      r0 = r0 + f;
    end
    @(negedge clk);
    check(tag, phase_o, r2);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    r0 = '0; r1 = '0; r2 = '0;
    repeat (2) @(negedge clk);
    check("R5 reset state", phase_o, 24'h0);
    rst_ni = 1'b1;
  endtask

  initial begin
    rst_ni = 1'b0;
    en_i   = 1'b0;
    ftw_i  = '0;
    @(negedge clk);
    do_reset();

    // Vector table walk (R2 against the reference accumulator)
    foreach (VEC[i]) step(VEC[i][24], VEC[i][23:0], "R2 vector");
    for (int i = 0; i < 3; i++) step(1'b1, 24'h0, "R2 drain");

    // R8: zero tuning word leaves phase constant once drained
    for (int i = 0; i < 3; i++) step(1'b1, 24'h0, "R8 zero word");
    check("R8 constant", phase_o, r2);

    // R3: carry across a byte boundary
    do_reset();
    step(1'b1, 24'h0000FF, "R3 setup");
    step(1'b1, 24'h000001, "R3 setup");
    step(1'b1, 24'h000000, "R3 carry");
    step(1'b1, 24'h000000, "R3 carry");
    check("R3 byte carry", phase_o, 24'h000100);

    // R4: full propagate chain, 0xFFFFFF acts as decrement
    do_reset();
    step(1'b1, 24'h000005, "R4 setup");
    for (int i = 0; i < 8; i++) step(1'b1, 24'hFFFFFF, "R4 propagate");
    step(1'b1, 24'h0, "R4 drain");
    step(1'b1, 24'h0, "R4 drain");
    check("R4 decrement", phase_o, 24'hFFFFFD);

    // R1: wrap past 2^24
    do_reset();
    for (int i = 0; i < 5; i++) step(1'b1, 24'h900000, "R1 wrap");
    step(1'b1, 24'h0, "R1 drain");
    step(1'b1, 24'h0, "R1 drain");
    check("R1 wrapped", phase_o, 24'hD00000);

    // R6: stall with changing word, then resume
    do_reset();
    for (int i = 0; i < 4; i++) step(1'b1, 24'h0180FF, "R6 run");
    for (int i = 0; i < 5; i++) step(1'b0, 24'h5A5A5A ^ 24'(i), "R6 stall");
    for (int i = 0; i < 4; i++) step(1'b1, 24'h0180FF, "R6 resume");

    // R7: clean step at a tuning-word change
    do_reset();
    for (int i = 0; i < 4; i++) step(1'b1, 24'h00F0F0, "R7 old word");
    for (int i = 0; i < 4; i++) begin
      logic [23:0] prev;
      prev = phase_o;
      step(1'b1, 24'h0F0F0F, "R7 new word");
      check("R7 increment", phase_o - prev, (i < 2) ? 24'h00F0F0 : 24'h0F0F0F);
    end

    // R5: asynchronous reset in mid-run clears output before any edge
    #1;
    rst_ni = 1'b0;
    #1;
    check("R5 async clear", phase_o, 24'h0);
    r0 = '0; r1 = '0; r2 = '0;
    @(negedge clk);
    rst_ni = 1'b1;
    for (int i = 0; i < 4; i++) step(1'b1, 24'h000777, "R5 after reset");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule